// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Port

A general-purpose I/O port whose line count equals its register width (8, 16, 32 or 64). Software reaches it through a plain synchronous register bus: a two-bit word address, a write strobe, write data with per-byte lane enables, and registered read data. The pad side is three vectors, one bit per line: the driven level, the drive enable and the sensed level. The sensed level crosses a two-flop synchroniser before software can read it.

The output-write style and the meaning of the direction register are fixed at elaboration. The output latch is either changed through a pair of set and clear strobes, or loaded whole through one output register that may be made readable. The direction register is absent (every line is always driven), one-means-output, or one-means-input. For big-endian hosts the register view can be bit-reversed, byte-swapped for 16- and 32-bit ports, or both. A 64-bit port with byte swap, or a width outside the legal set, stops elaboration.

Top module: `gpio_mmio_port`

## Requirements
- R1: After reset the output latch is all zero and every line is an input: drive enable low in both direction modes, and the direction register reads all ones in one-means-input mode and zero in one-means-output mode.
- R2: Word offset 0 returns the synchronised sensed level of every line. Writes to offset 0 change neither driven levels nor drive enables.
- R3: A sensed level change is seen by a read of offset 0 captured on the third rising edge after the change, and not earlier.
- R4: In set/clear style, a 1 written to offset 1 drives that line high and a 1 written to offset 2 drives it low. Zero bits leave their lines alone. Both offsets read as zero.
- R5: In single-register style, a write to offset 1 loads the latch. Offset 1 reads back the latch when readable and zero otherwise. Writes to offset 2 are ignored and it reads zero.
- R6: Only the bus byte lanes whose enable is set are written. With the write strobe low, no output or drive enable changes.
- R7: In one-means-output mode, a 1 at offset 3 enables drive on that line.
- R8: In one-means-input mode, a 1 at offset 3 turns drive off for that line.
- R9: With no direction register, every drive enable stays high, offset 3 reads zero and writes to it are ignored.
- R10: With bit reversal, line n sits at register bit WIDTH-1-n in every register.
- R11: With byte swap, bus byte lane k holds register byte NBYTES-1-k, byte enables follow bus lanes, and it combines with bit reversal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Word offset: 0 level, 1 set/output, 2 clear, 3 direction |
| bus_we | input | 1 | Write strobe |
| bus_be | input | WIDTH/8 | Byte lane enables, bus order |
| bus_wdata | input | WIDTH | Write data, bus order |
| bus_rdata | output | WIDTH | Read data for the offset of the previous cycle |
| gpio_in | input | WIDTH | Sensed pad levels, asynchronous |
| gpio_out | output | WIDTH | Driven levels from the output latch |
| gpio_oe | output | WIDTH | Drive enables |

## Verification
A corrupted output or direction latch shows on gpio_out or gpio_oe on the cycle after the write that set it up, and stays visible, since both outputs come straight from the latches. A wrong lane or bit mapping shows as a mirrored or shifted pattern in the first asymmetric write and in the read-back one cycle later. A synchroniser with the wrong depth moves the level read by one cycle, caught by reading offset 0 on three consecutive edges after a pin change.

// File: rtl/gpio_mmio_pkg.sv
`timescale 1ns/1ps
package gpio_mmio_pkg;
  typedef enum logic {
    OUT_SET_CLEAR = 1'b0,
    OUT_SINGLE    = 1'b1
  } out_style_e;

  typedef enum logic [1:0] {
    DIR_FIXED      = 2'd0,
    DIR_ONE_IS_OUT = 2'd1,
    DIR_ONE_IS_IN  = 2'd2
  } dir_mode_e;

  localparam logic [1:0] OFS_LEVEL = 2'd0;
  localparam logic [1:0] OFS_SET   = 2'd1;
  localparam logic [1:0] OFS_CLR   = 2'd2;
  localparam logic [1:0] OFS_DIR   = 2'd3;
endpackage

// File: rtl/gpio_view_map.sv
`timescale 1ns/1ps
// Permutes between bus order and line order. The permutation is its own
// inverse, so the same block serves both directions.
module gpio_view_map #(
  parameter int WIDTH     = 32,
  parameter bit BIT_REV   = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] word_out
);
  localparam int NBYTES = WIDTH / 8;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int LANE    = i / 8;
    localparam int POS     = i % 8;
    localparam int SWAPPED = BYTE_SWAP ? ((NBYTES - 1 - LANE) * 8 + POS) : i;
    localparam int SRC     = BIT_REV ? (WIDTH - 1 - SWAPPED) : SWAPPED;
    assign word_out[i] = word_in[SRC];
  end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= pin_async;
      stage2_q <= stage1_q;
    end
  end

  assign pin_sync = stage2_q;
endmodule

// File: rtl/gpio_out_latch.sv
`timescale 1ns/1ps
module gpio_out_latch
  import gpio_mmio_pkg::*;
#(
  parameter int         WIDTH     = 32,
  parameter out_style_e OUT_STYLE = OUT_SET_CLEAR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [WIDTH-1:0] wr_bits,
  input  logic [WIDTH-1:0] wr_mask,
  output logic [WIDTH-1:0] out_q
);
  logic [WIDTH-1:0] out_d;
  logic             out_en;
  logic [WIDTH-1:0] hit;

  assign hit = wr_bits & wr_mask;

  if (OUT_STYLE == OUT_SET_CLEAR) begin : g_setclr
    always_comb begin
      out_en = wr_set | wr_clr;
      out_d  = out_q;
      if (wr_set) out_d = out_d | hit;
      if (wr_clr) out_d = out_d & ~hit;
    end
  end else begin : g_single
    logic unused_clr;
    assign unused_clr = wr_clr;
    always_comb begin
      out_en = wr_set;
      out_d  = (out_q & ~wr_mask) | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end
endmodule

// File: rtl/gpio_dir_latch.sv
`timescale 1ns/1ps
module gpio_dir_latch
  import gpio_mmio_pkg::*;
#(
  parameter int        WIDTH    = 32,
  parameter dir_mode_e DIR_MODE = DIR_ONE_IS_OUT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic [WIDTH-1:0] wr_bits,
  input  logic [WIDTH-1:0] wr_mask,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] oe
);
  if (DIR_MODE == DIR_FIXED) begin : g_fixed
    logic unused_inputs;
    assign unused_inputs = wr_dir ^ (^wr_bits) ^ (^wr_mask) ^ clk ^ rst_n;
    assign dir_q = '0;
    assign oe    = '1;
  end else begin : g_reg
    localparam logic [WIDTH-1:0] RST_VAL = {WIDTH{DIR_MODE == DIR_ONE_IS_IN}};
    logic [WIDTH-1:0] dir_d;

    always_comb dir_d = (dir_q & ~wr_mask) | (wr_bits & wr_mask);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= RST_VAL;
      else if (wr_dir) dir_q <= dir_d;
    end

    if (DIR_MODE == DIR_ONE_IS_OUT) begin : g_pos
      assign oe = dir_q;
    end else begin : g_neg
      assign oe = ~dir_q;
    end
  end
endmodule

// File: rtl/gpio_mmio_port.sv
`timescale 1ns/1ps
module gpio_mmio_port
  import gpio_mmio_pkg::*;
#(
  parameter int         WIDTH        = 32,
  parameter out_style_e OUT_STYLE    = OUT_SET_CLEAR,
  parameter bit         OUT_READABLE = 1'b1,
  parameter dir_mode_e  DIR_MODE     = DIR_ONE_IS_OUT,
  parameter bit         BIT_REV      = 1'b0,
  parameter bit         BYTE_SWAP    = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           bus_addr,
  input  logic                 bus_we,
  input  logic [WIDTH/8-1:0]   bus_be,
  input  logic [WIDTH-1:0]     bus_wdata,
  output logic [WIDTH-1:0]     bus_rdata,
  input  logic [WIDTH-1:0]     gpio_in,
  output logic [WIDTH-1:0]     gpio_out,
  output logic [WIDTH-1:0]     gpio_oe
);
  localparam int NBYTES   = WIDTH / 8;
  localparam bit SHOW_OUT = (OUT_STYLE == OUT_SINGLE) && OUT_READABLE;

  if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
    $error("gpio_mmio_port: WIDTH must be 8, 16, 32 or 64");
  end
  if (BYTE_SWAP && WIDTH == 64) begin : g_bad_swap
    $error("gpio_mmio_port: byte swap is not available at 64 bits");
  end

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Bus order to line order.
  logic [WIDTH-1:0] bus_mask;
  logic [WIDTH-1:0] wr_bits;
  logic [WIDTH-1:0] wr_mask;
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign bus_mask[k*8 +: 8] = {8{bus_be[k]}};
  end

  gpio_view_map #(.WIDTH(WIDTH), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_map_wdata (
    .word_in (bus_wdata),
    .word_out(wr_bits)
  );
  gpio_view_map #(.WIDTH(WIDTH), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_map_mask (
    .word_in (bus_mask),
    .word_out(wr_mask)
  );

  // Decode.
  logic wr_set, wr_clr, wr_dir;
  assign wr_set = bus_we && (bus_addr == OFS_SET);
  assign wr_clr = bus_we && (bus_addr == OFS_CLR);
  assign wr_dir = bus_we && (bus_addr == OFS_DIR);

  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] oe;
  logic [WIDTH-1:0] pin_sync;

  gpio_out_latch #(.WIDTH(WIDTH), .OUT_STYLE(OUT_STYLE)) u_out (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_set (wr_set),
    .wr_clr (wr_clr),
    .wr_bits(wr_bits),
    .wr_mask(wr_mask),
    .out_q  (out_q)
  );

  gpio_dir_latch #(.WIDTH(WIDTH), .DIR_MODE(DIR_MODE)) u_dir (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_dir (wr_dir),
    .wr_bits(wr_bits),
    .wr_mask(wr_mask),
    .dir_q  (dir_q),
    .oe     (oe)
  );

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin_async(gpio_in),
    .pin_sync (pin_sync)
  );

  // Read path: select in line order, map back to bus order, register.
  logic [WIDTH-1:0] rd_line;
  logic [WIDTH-1:0] rd_bus;
  logic [WIDTH-1:0] rdata_q;

  always_comb begin
    unique case (bus_addr)
      OFS_LEVEL: rd_line = pin_sync;
      OFS_SET:   rd_line = SHOW_OUT ? out_q : '0;
      OFS_CLR:   rd_line = '0;
      default:   rd_line = dir_q;
    endcase
  end

  gpio_view_map #(.WIDTH(WIDTH), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_map_rd (
    .word_in (rd_line),
    .word_out(rd_bus)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rd_bus;
  end

  assign bus_rdata = rdata_q;
  assign gpio_out  = out_q;
  assign gpio_oe   = oe;
endmodule

// File: rtl/gpio_mmio_port_chk.sv
`timescale 1ns/1ps
module gpio_mmio_port_chk
  import gpio_mmio_pkg::*;
#(
  parameter int         WIDTH     = 32,
  parameter out_style_e OUT_STYLE = OUT_SET_CLEAR,
  parameter dir_mode_e  DIR_MODE  = DIR_ONE_IS_OUT
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_we,
  input logic [WIDTH-1:0] wr_bits,
  input logic [WIDTH-1:0] wr_mask,
  input logic [WIDTH-1:0] gpio_out,
  input logic [WIDTH-1:0] gpio_oe
);
  localparam bit HAS_DIR = (DIR_MODE != DIR_FIXED);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (gpio_out == '0) && (!HAS_DIR || gpio_oe == '0));

  assert_level_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_LEVEL) |=> $stable(gpio_out) && $stable(gpio_oe));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(gpio_out) && $stable(gpio_oe));

  if (OUT_STYLE == OUT_SET_CLEAR) begin : g_setclr
    assert_set_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_SET) |=>
        ((gpio_out & $past(wr_bits & wr_mask)) == $past(wr_bits & wr_mask)));
    assert_clr_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_CLR) |=> ((gpio_out & $past(wr_bits & wr_mask)) == '0));
  end else begin : g_single
    assert_single_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_SET) |=> (((gpio_out ^ $past(wr_bits)) & $past(wr_mask)) == '0));
    assert_clr_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_CLR) |=> $stable(gpio_out));
  end

  if (DIR_MODE == DIR_ONE_IS_OUT) begin : g_dout
    assert_dir_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_DIR) |=> (((gpio_oe ^ $past(wr_bits)) & $past(wr_mask)) == '0));
  end else if (DIR_MODE == DIR_ONE_IS_IN) begin : g_din
    assert_dir_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_DIR) |=> (((~gpio_oe ^ $past(wr_bits)) & $past(wr_mask)) == '0));
  end else begin : g_dnone
    assert_dir_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_DIR) |=> $stable(gpio_oe));
  end
endmodule

bind gpio_mmio_port gpio_mmio_port_chk #(
  .WIDTH(WIDTH), .OUT_STYLE(OUT_STYLE), .DIR_MODE(DIR_MODE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .bus_addr(bus_addr),
  .bus_we  (bus_we),
  .wr_bits (wr_bits),
  .wr_mask (wr_mask),
  .gpio_out(gpio_out),
  .gpio_oe (gpio_oe)
);

// File: tb/test_gpio_mmio_port.sv
`timescale 1ns/1ps
module test_gpio_mmio_port;
  import gpio_mmio_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [1:0]  addr;
  logic [63:0] wdata;
  logic [7:0]  be;
  logic        we_a, we_b, we_c;

  logic [31:0] rd_a, out_a, oe_a, pin_a, ext_a;
  logic [15:0] rd_b, out_b, oe_b, pin_b, ext_b;
  logic [7:0]  rd_c, out_c, oe_c, pin_c, ext_c;

  // Pad model: a driven line reads back its own level.
  assign pin_a = (oe_a & out_a) | (~oe_a & ext_a);
  assign pin_b = (oe_b & out_b) | (~oe_b & ext_b);
  assign pin_c = (oe_c & out_c) | (~oe_c & ext_c);

  // A: 32 bit, set/clear, one-means-output, natural order.
  gpio_mmio_port #(.WIDTH(32), .OUT_STYLE(OUT_SET_CLEAR), .OUT_READABLE(1'b0),
    .DIR_MODE(DIR_ONE_IS_OUT), .BIT_REV(1'b0), .BYTE_SWAP(1'b0)) i_gpio_mmio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we_a), .bus_be(be[3:0]),
    .bus_wdata(wdata[31:0]), .bus_rdata(rd_a), .gpio_in(pin_a), .gpio_out(out_a), .gpio_oe(oe_a));

  // B: 16 bit, readable single register, one-means-input, bit and byte reversed.
  gpio_mmio_port #(.WIDTH(16), .OUT_STYLE(OUT_SINGLE), .OUT_READABLE(1'b1),
    .DIR_MODE(DIR_ONE_IS_IN), .BIT_REV(1'b1), .BYTE_SWAP(1'b1)) i_gpio_mmio_port_be (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we_b), .bus_be(be[1:0]),
    .bus_wdata(wdata[15:0]), .bus_rdata(rd_b), .gpio_in(pin_b), .gpio_out(out_b), .gpio_oe(oe_b));

  // C: 8 bit, unreadable single register, no direction register, bit reversed.
  gpio_mmio_port #(.WIDTH(8), .OUT_STYLE(OUT_SINGLE), .OUT_READABLE(1'b0),
    .DIR_MODE(DIR_FIXED), .BIT_REV(1'b1), .BYTE_SWAP(1'b0)) i_gpio_mmio_port_rev (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we_c), .bus_be(be[0:0]),
    .bus_wdata(wdata[7:0]), .bus_rdata(rd_c), .gpio_in(pin_c), .gpio_out(out_c), .gpio_oe(oe_c));

  int checks   = 0;
  int failures = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Line order <-> bus order, written from R10/R11.
  function automatic logic [63:0] vmap(logic [63:0] x, int w, bit brev, bit bswap);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) begin
      int j = bswap ? ((w / 8 - 1 - i / 8) * 8 + i % 8) : i;
      if (brev) j = w - 1 - j;
      r[i] = x[j];
    end
    return r;
  endfunction

  // Scoreboard.
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req;
  int          rd_sel;
  logic        rd_stage;
  int          sel_stage;

  always @(posedge clk) begin
    rd_stage  <= rd_req;
    sel_stage <= rd_sel;
  end

  always @(negedge clk) begin
    if (rd_stage) begin
      logic [63:0] act;
      act = (sel_stage == 0) ? {32'b0, rd_a} : (sel_stage == 1) ? {48'b0, rd_b} : {56'b0, rd_c};
      if (exp_q.size() == 0) chk("scoreboard underflow", act, 64'hx);
      else chk(tag_q.pop_front(), act, exp_q.pop_front());
    end
  end

  // Tasks start and end 1 ns after a rising edge.
  task automatic wr(int sel, logic [1:0] a, logic [63:0] d, logic [7:0] b);
    addr = a; wdata = d; be = b;
    we_a = (sel == 0); we_b = (sel == 1); we_c = (sel == 2);
    @(posedge clk); #1;
    we_a = 1'b0; we_b = 1'b0; we_c = 1'b0;
  endtask

  task automatic rd(int sel, logic [1:0] a, logic [63:0] e, string tag);
    addr = a; rd_sel = sel; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; be = '0;
    we_a = 1'b0; we_b = 1'b0; we_c = 1'b0; rd_req = 1'b0; rd_sel = 0;
    ext_a = '0; ext_b = '0; ext_c = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(3);

    // R1 / R9 reset state.
    chk("R1 out A", out_a, 0);
    chk("R1 oe A", oe_a, 0);
    chk("R1 out B", out_b, 0);
    chk("R1 R8 oe B", oe_b, 0);
    chk("R9 oe C", oe_c, 64'hFF);
    rd(0, OFS_DIR, 0, "R1 dir A");
    rd(1, OFS_DIR, 64'hFFFF, "R1 R8 dir B");

    // Instance A: set/clear.
    wr(0, OFS_SET, 64'h0000_00F0, 8'hF);
    chk("R4 set A", out_a, 64'hF0);
    wr(0, OFS_SET, 64'h0F00_0001, 8'h1);
    chk("R6 lane mask A", out_a, 64'hF1);
    wr(0, OFS_CLR, 64'h0000_0030, 8'hF);
    chk("R4 clear A", out_a, 64'hC1);
    rd(0, OFS_SET, 0, "R4 set reads zero");
    rd(0, OFS_CLR, 0, "R4 clr reads zero");
    wr(0, OFS_LEVEL, 64'hFFFF_FFFF, 8'hF);
    chk("R2 level write out A", out_a, 64'hC1);
    chk("R2 level write oe A", oe_a, 0);
    wr(0, OFS_DIR, 64'h0000_00FF, 8'hF);
    chk("R7 oe A", oe_a, 64'hFF);
    rd(0, OFS_DIR, 64'hFF, "R7 dir readback");

    // A: level read and synchroniser latency.
    ext_a = 32'hA5A5_0000;
    idle(4);
    rd(0, OFS_LEVEL, 64'hA5A5_00C1, "R2 level A");
    ext_a = 32'h5A5A_0000;
    rd(0, OFS_LEVEL, 64'hA5A5_00C1, "R3 edge1 old");
    rd(0, OFS_LEVEL, 64'hA5A5_00C1, "R3 edge2 old");
    rd(0, OFS_LEVEL, 64'h5A5A_00C1, "R3 edge3 new");

    // Instance B: single register, reversed view.
    wr(1, OFS_SET, 64'h0101, 8'h3);
    chk("R10 R11 out B", out_b, vmap(64'h0101, 16, 1'b1, 1'b1));
    wr(1, OFS_SET, 64'h0000, 8'h1);
    chk("R6 R11 lane B", out_b, 64'h8000);
    rd(1, OFS_SET, vmap(64'h8000, 16, 1'b1, 1'b1), "R5 readback B");
    wr(1, OFS_DIR, 64'h00FE, 8'h3);
    chk("R8 oe B", oe_b, ~vmap(64'h00FE, 16, 1'b1, 1'b1) & 64'hFFFF);
    rd(1, OFS_DIR, 64'h00FE, "R8 dir readback B");
    wr(1, OFS_CLR, 64'hFFFF, 8'h3);
    chk("R5 clr ignored B", out_b, 64'h8000);
    rd(1, OFS_CLR, 0, "R5 clr reads zero B");
    ext_b = 16'h1234;
    idle(4);
    rd(1, OFS_LEVEL, vmap((64'h8000 & 64'hFF80) | (64'h1234 & 64'h007F), 16, 1'b1, 1'b1),
       "R2 R11 level B");

    // Instance C: no direction register, bit reversed.
    wr(2, OFS_SET, 64'h03, 8'h1);
    chk("R10 out C", out_c, 64'hC0);
    rd(2, OFS_SET, 0, "R5 unreadable C");
    wr(2, OFS_DIR, 64'h00, 8'h1);
    chk("R9 oe C after write", oe_c, 64'hFF);
    rd(2, OFS_DIR, 0, "R9 dir reads zero");
    idle(3);
    rd(2, OFS_LEVEL, 64'h03, "R10 level C");

    idle(3);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule